// File: doc/BRIEF.md
# Branch Confidence Estimator with Predication Steering

This block judges, branch by branch, whether the direction predictor is likely to get a branch wrong. It keeps a table of small saturating counters that count recent mispredictions. The table is indexed with the same hash of fetch address and global history that the direction predictor uses. A counter rises on every resolved misprediction and falls on every correct prediction, so a branch that becomes easy to predict again regains confidence.

Fetch issues a lookup that carries the branch address, the history, the branch kind and a confidence threshold. One cycle later the block answers with a confidence verdict and a steering decision. A low-confidence wish jump, wish join or wish loop is steered to predicated execution, which fetches both paths under the guard predicate. A high-confidence wish branch runs as normal predicted branch code, with the predicate treated as always true. A low-confidence ordinary conditional branch has no predicated form, so for that branch the block raises a fetch-gating request that lets fetch stall to save energy. The back end reports resolved branches on a separate update port.

Top module: `bconf_steer`

## Requirements
- R1: After reset every counter reads zero, so every lookup with a threshold below 15 reports high confidence, and no response is flagged valid until a lookup has been made.
- R2: The table index is pc[11:2] XOR ghist[9:0]. Lookups and updates whose indices are equal share one counter, even when their address and history differ.
- R3: An update with the mispredict flag set raises the selected counter by one, and the counter holds at 15.
- R4: An update with the mispredict flag clear lowers the selected counter by one, and the counter holds at 0 instead of wrapping.
- R5: A response reports low confidence exactly when the counter is strictly greater than the threshold given with the lookup.
- R6: rsp_valid_o is high in the cycle after a cycle with lkp_valid_i high, and low otherwise.
- R7: When a lookup and an update hit the same index in the same cycle, the lookup returns the counter value from before the update. The update still takes effect for later lookups.
- R8: Branch kind encoding is 0 plain conditional, 1 wish jump, 2 wish join and 3 wish loop. rsp_pred_o is high exactly when the response is valid, the confidence is low and the kind is 1, 2 or 3.
- R9: rsp_gate_o is high exactly when the response is valid, the confidence is low and the kind is 0. It is never high together with rsp_pred_o.
- R10: A threshold of 15 never yields low confidence, predicated mode or fetch gating.
- R11: The threshold and kind are captured with the lookup. Changing them in the response cycle does not alter that response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lkp_valid_i | input | 1 | Lookup request |
| lkp_pc_i | input | 32 | Branch address for the lookup |
| lkp_ghist_i | input | 10 | Global history for the lookup |
| lkp_kind_i | input | 2 | Branch kind (0 plain, 1 wish jump, 2 wish join, 3 wish loop) |
| lkp_thresh_i | input | 4 | Confidence threshold for this lookup |
| upd_valid_i | input | 1 | Resolved branch report |
| upd_pc_i | input | 32 | Address of the resolved branch |
| upd_ghist_i | input | 10 | History the resolved branch was predicted with |
| upd_mispred_i | input | 1 | The resolved branch was mispredicted |
| rsp_valid_o | output | 1 | Response for the previous cycle's lookup |
| rsp_low_conf_o | output | 1 | Counter exceeds the threshold |
| rsp_pred_o | output | 1 | Run the wish branch as predicated code |
| rsp_gate_o | output | 1 | Request a fetch stall for a hard plain branch |

## Verification
The bench pushes one entry to saturation at 15 and checks thresholds 14 and 15 there. A counter that wraps, or a compare that is not strict, would flip the verdict at one of these points. It drains an entry past zero with correct predictions and then looks it up with threshold 0; a counter that underflows would then report low confidence. It issues a lookup and an update to the same index in one cycle, where a design that forwards the write would return the new count. It reaches one counter through two different address and history pairs, and changes the threshold and kind in the response cycle to show that these inputs were captured at the lookup.

// File: rtl/bconf_pkg.sv
package bconf_pkg;
  typedef enum logic [1:0] {
    BR_PLAIN = 2'd0,
    BR_WJUMP = 2'd1,
    BR_WJOIN = 2'd2,
    BR_WLOOP = 2'd3
  } br_kind_e;
endpackage

// File: rtl/bconf_index.sv
module bconf_index #(
  parameter int PC_W   = 32,
  parameter int HIST_W = 10,
  parameter int IDX_W  = 10
) (
  input  logic [PC_W-1:0]   pc_i,
  input  logic [HIST_W-1:0] ghist_i,
  output logic [IDX_W-1:0]  idx_o
);
  logic [IDX_W-1:0] hist_fold;

  generate
    if (HIST_W >= IDX_W) begin : g_hist_trunc
      assign hist_fold = ghist_i[IDX_W-1:0];
    end else begin : g_hist_ext
      assign hist_fold = {{(IDX_W-HIST_W){1'b0}}, ghist_i};
    end
  endgenerate

  // word-aligned address bits, same hash as the direction predictor
  assign idx_o = pc_i[IDX_W+1:2] ^ hist_fold;
endmodule

// File: rtl/bconf_table.sv
module bconf_table #(
  parameter int IDX_W = 10,
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_en_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [CNT_W-1:0] rd_cnt_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_miss_i
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q [DEPTH];
  logic [CNT_W-1:0] rd_q;
  logic [CNT_W-1:0] cur_cnt, nxt_cnt;

  assign cur_cnt = cnt_q[wr_idx_i];

  always_comb begin
    nxt_cnt = cur_cnt;
    if (wr_miss_i) begin
      if (cur_cnt != CNT_MAX) nxt_cnt = cur_cnt + 1'b1;
    end else begin
      if (cur_cnt != '0) nxt_cnt = cur_cnt - 1'b1;
    end
  end

  // read samples pre-update contents on a same-index collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) cnt_q[i] <= '0;
      rd_q <= '0;
    end else begin
      if (rd_en_i) rd_q <= cnt_q[rd_idx_i];
      if (wr_en_i) cnt_q[wr_idx_i] <= nxt_cnt;
    end
  end

  assign rd_cnt_o = rd_q;
endmodule

// File: rtl/bconf_decide.sv
module bconf_decide
  import bconf_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             vld_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] thr_i,
  input  br_kind_e         kind_i,
  output logic             low_o,
  output logic             pred_o,
  output logic             gate_o
);
  logic hard;

  assign hard   = cnt_i > thr_i;
  assign low_o  = vld_i && hard;
  assign pred_o = low_o && (kind_i != BR_PLAIN);
  assign gate_o = low_o && (kind_i == BR_PLAIN);
endmodule

// File: rtl/bconf_steer.sv
module bconf_steer
  import bconf_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int HIST_W = 10,
  parameter int IDX_W  = 10,
  parameter int CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lkp_valid_i,
  input  logic [PC_W-1:0]   lkp_pc_i,
  input  logic [HIST_W-1:0] lkp_ghist_i,
  input  logic [1:0]        lkp_kind_i,
  input  logic [CNT_W-1:0]  lkp_thresh_i,
  input  logic              upd_valid_i,
  input  logic [PC_W-1:0]   upd_pc_i,
  input  logic [HIST_W-1:0] upd_ghist_i,
  input  logic              upd_mispred_i,
  output logic              rsp_valid_o,
  output logic              rsp_low_conf_o,
  output logic              rsp_pred_o,
  output logic              rsp_gate_o
);
  logic [IDX_W-1:0] lkp_idx, upd_idx;
  logic [CNT_W-1:0] rd_cnt;
  logic             vld_q;
  logic [CNT_W-1:0] thr_q;
  br_kind_e         kind_q;

  bconf_index #(.PC_W(PC_W), .HIST_W(HIST_W), .IDX_W(IDX_W)) u_idx_lkp (
    .pc_i(lkp_pc_i), .ghist_i(lkp_ghist_i), .idx_o(lkp_idx)
  );

  bconf_index #(.PC_W(PC_W), .HIST_W(HIST_W), .IDX_W(IDX_W)) u_idx_upd (
    .pc_i(upd_pc_i), .ghist_i(upd_ghist_i), .idx_o(upd_idx)
  );

  bconf_table #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_en_i   (lkp_valid_i),
    .rd_idx_i  (lkp_idx),
    .rd_cnt_o  (rd_cnt),
    .wr_en_i   (upd_valid_i),
    .wr_idx_i  (upd_idx),
    .wr_miss_i (upd_mispred_i)
  );

  // threshold and kind travel with the read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      thr_q  <= '0;
      kind_q <= BR_PLAIN;
    end else begin
      vld_q <= lkp_valid_i;
      if (lkp_valid_i) begin
        thr_q  <= lkp_thresh_i;
        kind_q <= br_kind_e'(lkp_kind_i);
      end
    end
  end

  bconf_decide #(.CNT_W(CNT_W)) u_decide (
    .vld_i  (vld_q),
    .cnt_i  (rd_cnt),
    .thr_i  (thr_q),
    .kind_i (kind_q),
    .low_o  (rsp_low_conf_o),
    .pred_o (rsp_pred_o),
    .gate_o (rsp_gate_o)
  );

  assign rsp_valid_o = vld_q;
endmodule

// File: rtl/bconf_steer_chk.sv
module bconf_steer_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             lkp_valid_i,
  input logic [1:0]       lkp_kind_i,
  input logic [CNT_W-1:0] lkp_thresh_i,
  input logic             rsp_valid_o,
  input logic             rsp_low_conf_o,
  input logic             rsp_pred_o,
  input logic             rsp_gate_o
);
  localparam logic [CNT_W-1:0] THR_OFF = {CNT_W{1'b1}};

  a_r6_rsp_after_lkp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_valid_i |=> rsp_valid_o);

  a_r6_no_rsp_without_lkp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkp_valid_i |=> !rsp_valid_o);

  a_r8_plain_never_pred: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_valid_i && lkp_kind_i == 2'd0) |=> !rsp_pred_o);

  a_r9_wish_never_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_valid_i && lkp_kind_i != 2'd0) |=> !rsp_gate_o);

  a_r9_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rsp_pred_o, rsp_gate_o}));

  a_r10_thresh_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_valid_i && lkp_thresh_i == THR_OFF) |=> !rsp_low_conf_o && !rsp_pred_o && !rsp_gate_o);

  a_r5_quiet_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> !rsp_low_conf_o && !rsp_pred_o && !rsp_gate_o);
endmodule

bind bconf_steer bconf_steer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .lkp_valid_i    (lkp_valid_i),
  .lkp_kind_i     (lkp_kind_i),
  .lkp_thresh_i   (lkp_thresh_i),
  .rsp_valid_o    (rsp_valid_o),
  .rsp_low_conf_o (rsp_low_conf_o),
  .rsp_pred_o     (rsp_pred_o),
  .rsp_gate_o     (rsp_gate_o)
);

// File: tb/bconf_steer_tb.sv
`timescale 1ns/1ps
module bconf_steer_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lkp_valid_i = 1'b0;
  logic [31:0] lkp_pc_i = '0;
  logic [9:0]  lkp_ghist_i = '0;
  logic [1:0]  lkp_kind_i = '0;
  logic [3:0]  lkp_thresh_i = '0;
  logic        upd_valid_i = 1'b0;
  logic [31:0] upd_pc_i = '0;
  logic [9:0]  upd_ghist_i = '0;
  logic        upd_mispred_i = 1'b0;
  logic        rsp_valid_o, rsp_low_conf_o, rsp_pred_o, rsp_gate_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int unsigned mdl [1024];

  always #4 clk_i = ~clk_i;

  bconf_steer u_dut (.*);

  function automatic int unsigned idx_of(input logic [31:0] pc, input logic [9:0] h);
    return int'(pc[11:2] ^ h);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle: optional lookup and update; checks the response when looked up
  task automatic cyc(input bit lv, input logic [31:0] lpc, input logic [9:0] lh,
                     input logic [1:0] kind, input logic [3:0] thr,
                     input bit uv, input logic [31:0] upc, input logic [9:0] uh,
                     input bit miss, input string req);
    bit e_low, e_pred, e_gate;
    int unsigned ui;
    @(negedge clk_i);
    lkp_valid_i = lv; lkp_pc_i = lpc; lkp_ghist_i = lh; lkp_kind_i = kind; lkp_thresh_i = thr;
    upd_valid_i = uv; upd_pc_i = upc; upd_ghist_i = uh; upd_mispred_i = miss;
    e_low  = lv && (mdl[idx_of(lpc, lh)] > int'(thr));
    e_pred = e_low && kind != 2'd0;
    e_gate = e_low && kind == 2'd0;
    if (uv) begin
      ui = idx_of(upc, uh);
      if (miss) begin if (mdl[ui] < 15) mdl[ui]++; end
      else begin if (mdl[ui] > 0) mdl[ui]--; end
    end
    @(posedge clk_i);
    #1;
    chk(rsp_valid_o == lv, "R6", int'(rsp_valid_o), int'(lv));
    if (lv) begin
      chk(rsp_low_conf_o == e_low, req, int'(rsp_low_conf_o), int'(e_low));
      chk(rsp_pred_o == e_pred, {req, "/R8"}, int'(rsp_pred_o), int'(e_pred));
      chk(rsp_gate_o == e_gate, {req, "/R9"}, int'(rsp_gate_o), int'(e_gate));
    end
  endtask

  task automatic upd(input logic [31:0] pc, input logic [9:0] h, input bit miss, input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, '0, '0, 2'd0, 4'd0, 1'b1, pc, h, miss, "R3");
  endtask

  task automatic look(input logic [31:0] pc, input logic [9:0] h, input logic [1:0] kind,
                      input logic [3:0] thr, input string req);
    cyc(1'b1, pc, h, kind, thr, 1'b0, '0, '0, 1'b0, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 1024; i++) mdl[i] = 0;
    repeat (3) @(posedge clk_i);
    #1;
    chk(!rsp_valid_o && !rsp_pred_o && !rsp_gate_o, "R1", int'(rsp_valid_o), 0);
    @(negedge clk_i) rst_ni = 1'b1;
    @(posedge clk_i); #1;
    chk(!rsp_valid_o, "R1", int'(rsp_valid_o), 0);

    // R1: fresh table is confident everywhere
    look(32'h100, 10'h0, 2'd1, 4'd0, "R1");
    look(32'hABC, 10'h3F, 2'd0, 4'd0, "R1");

    // R5 strict compare, R8/R9 steering
    upd(32'h100, 10'h0, 1'b1, 3);
    look(32'h100, 10'h0, 2'd1, 4'd2, "R5");
    look(32'h100, 10'h0, 2'd2, 4'd3, "R5");
    look(32'h100, 10'h0, 2'd3, 4'd2, "R8");
    look(32'h100, 10'h0, 2'd0, 4'd2, "R9");

    // R3 saturation at 15, R10 threshold 15
    upd(32'h100, 10'h0, 1'b1, 20);
    look(32'h100, 10'h0, 2'd1, 4'd14, "R3");
    look(32'h100, 10'h0, 2'd1, 4'd15, "R10");
    look(32'h100, 10'h0, 2'd0, 4'd15, "R10");

    // R2: aliased pair reaches the same counter
    look(32'h104, 10'h1, 2'd1, 4'd14, "R2");
    look(32'h104, 10'h0, 2'd1, 4'd0, "R2");

    // R7: same-index read and write in one cycle returns the old count
    cyc(1'b1, 32'h100, 10'h0, 2'd1, 4'd14, 1'b1, 32'h104, 10'h1, 1'b0, "R7");
    look(32'h100, 10'h0, 2'd1, 4'd14, "R7");

    // R4: drain past zero without wrapping
    upd(32'h100, 10'h0, 1'b0, 20);
    look(32'h100, 10'h0, 2'd1, 4'd0, "R4");
    upd(32'h100, 10'h0, 1'b1, 1);
    look(32'h100, 10'h0, 2'd1, 4'd0, "R4");

    // R11: threshold and kind captured with the lookup
    upd(32'h100, 10'h0, 1'b1, 4);
    look(32'h100, 10'h0, 2'd1, 4'd2, "R11");
    lkp_valid_i = 1'b0; lkp_thresh_i = 4'd15; lkp_kind_i = 2'd0;
    #1;
    chk(rsp_low_conf_o && rsp_pred_o && !rsp_gate_o, "R11", int'(rsp_pred_o), 1);

    // random mix over a small set of aliasing addresses
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] lpc, upc;
      logic [9:0]  lh, uh;
      lpc = 32'h200 + 32'(($urandom % 6) * 4);
      upc = 32'h200 + 32'(($urandom % 6) * 4);
      lh  = 10'($urandom % 4);
      uh  = 10'($urandom % 4);
      cyc(($urandom % 4) != 0, lpc, lh, 2'($urandom % 4), 4'($urandom % 16),
          ($urandom % 3) != 0, upc, uh, ($urandom % 5) < 3, "R5");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule